// File: doc/BRIEF.md
# Two-Word Instruction Fetch Decoder

This block sits at the front of a small 16-bit processor. It reads instruction words from program memory through a simple request/valid read port. It splits each word into a 5-bit instruction class (bits 15..11), a 3-bit addressing mode (bits 10..8) and an 8-bit post-byte (bits 7..0). From the class and mode it decides whether the instruction takes a second 16-bit word, the post-word, and fetches that word from the next address when one is needed. The assembled result is offered downstream through a valid/ready handshake.

Opcodes in the five reserved classes, and the one unassigned slot of the second extended class, are not presented downstream. For these the block pulses an exception request for one cycle and moves on to the following word. The block does not generate operand addresses, does not execute anything and does not enter interrupts.

The controller has four states. FETCH_OP requests the word at the program counter. FETCH_PW requests the word at program counter + 1. PRESENT drives the decoded bundle. TRAP pulses the exception. The transitions are:
- FETCH_OP to TRAP when the returned word is illegal.
- FETCH_OP to FETCH_PW when the returned word needs a post-word.
- FETCH_OP to PRESENT when the returned word is a legal single-word instruction.
- FETCH_PW to PRESENT when the post-word returns.
- PRESENT to FETCH_OP when the consumer accepts the bundle.
- TRAP to FETCH_OP always, one cycle later.

Top module: `ifd_fetch_decoder`

## Requirements
- R1: One cycle after synchronous reset is released, mem_req is 1, mem_addr equals RESET_PC, and both dec_valid and exc_opcode are 0.
- R2: The bundle gives dec_class = word[15:11], dec_mode = word[10:8], dec_postbyte = word[7:0], dec_reg_lo = word[3:0] and dec_reg_hi = word[7:4].
- R3: The following forms are single-word:
  - mode 3 in classes 0x00-0x11, 0x14, 0x15 and 0x18;
  - mode 0 in classes 0x01, 0x06-0x0A, 0x0E, 0x0F, 0x11, 0x12, 0x15 and 0x18;
  - modes 0 and 4 of class 0x17;
  - modes 3-7 of class 0x1E;
  - modes 1-7 of class 0x1F.

  For these no second read is made, dec_two_word is 0 and dec_postword is 0.
- R4: Every other legal class/mode pair reads a post-word at the instruction address + 1. dec_valid rises only after that word has returned, with dec_postword equal to it and dec_two_word 1.
- R5: In class 0x12 only mode 0 is single-word, and in classes 0x13 and 0x16 every mode carries a post-word.
- R6: After a bundle is accepted (dec_valid and dec_ready both 1), the next instruction read is at dec_pc + 1 for a single-word instruction and at dec_pc + 2 for a two-word instruction.
- R7: Any opcode of classes 0x19-0x1D, and class 0x1F mode 0, makes exc_opcode high for exactly one cycle. No post-word is read, dec_valid stays low, and the next read is at the instruction address + 1.
- R8: While dec_valid is 1 and dec_ready is 0, the bundle holds steady and mem_req stays 0.
- R9: mem_req, once raised, stays high with mem_addr unchanged until mem_rvalid is returned.
- R10: dec_pc gives the address from which the instruction word was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Program memory read address |
| mem_req | output | 1 | Read request, held until data returns |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid, one cycle per request |
| dec_valid | output | 1 | Decoded bundle valid |
| dec_ready | input | 1 | Consumer accepts the bundle |
| dec_class | output | 5 | Instruction class |
| dec_mode | output | 3 | Addressing mode |
| dec_postbyte | output | 8 | Full post-byte (port, segment or bit mask) |
| dec_reg_lo | output | 4 | Low post-byte nibble (register selector) |
| dec_reg_hi | output | 4 | High post-byte nibble (register selector) |
| dec_postword | output | 16 | Post-word, 0 for single-word forms |
| dec_two_word | output | 1 | Instruction carried a post-word |
| dec_pc | output | ADDR_W | Address of the instruction word |
| exc_opcode | output | 1 | One-cycle illegal-opcode exception request |

## Verification
The checks assume that program memory only answers a pending request: mem_rvalid is asserted only while mem_req is high, at most once per request. The bench memory model keeps to this. It raises mem_rvalid from a held request after a latency of zero to two cycles, and drops it for a cycle after every delivery. The consumer side is free to stall, and the bench drives dec_ready low in a repeating pattern. This exercises the hold behaviour without breaking any input assumption.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int WORD_W  = 16;
    localparam int CLASS_W = 5;
    localparam int MODE_W  = 3;
    localparam int PB_W    = WORD_W - CLASS_W - MODE_W;
    localparam int NIB_W   = PB_W / 2;

    typedef logic [CLASS_W-1:0] cls_t;
    typedef logic [MODE_W-1:0]  mode_t;

    typedef enum logic [1:0] {
        ST_FETCH_OP = 2'd0,
        ST_FETCH_PW = 2'd1,
        ST_PRESENT  = 2'd2,
        ST_TRAP     = 2'd3
    } ifd_state_t;

    localparam cls_t CL_STORE  = 5'h01;
    localparam cls_t CL_SHL    = 5'h06;
    localparam cls_t CL_SRA    = 5'h0A;
    localparam cls_t CL_ROL    = 5'h0E;
    localparam cls_t CL_ROR    = 5'h0F;
    localparam cls_t CL_TEST   = 5'h11;
    localparam cls_t CL_IN     = 5'h12;
    localparam cls_t CL_OUT    = 5'h13;
    localparam cls_t CL_PULL   = 5'h15;
    localparam cls_t CL_JUMP   = 5'h16;
    localparam cls_t CL_BRANCH = 5'h17;
    localparam cls_t CL_NEG    = 5'h18;
    localparam cls_t CL_RSV_LO = 5'h19;
    localparam cls_t CL_RSV_HI = 5'h1D;
    localparam cls_t CL_EXT_A  = 5'h1E;
    localparam cls_t CL_EXT_B  = 5'h1F;

    localparam mode_t MD_ZERO  = 3'd0;
    localparam mode_t MD_REG   = 3'd3;
    localparam mode_t MD_EXT_LAST_PW = 3'd2;

endpackage

// File: rtl/ifd_opclass.sv
module ifd_opclass
    import ifd_pkg::*;
(
    input  cls_t  op_cls,
    input  mode_t op_mode,
    output logic  op_legal,
    output logic  op_two
);

    logic zero_mode_is_reg;

    // Classes whose mode 0 is a register or dummy form (no post-word)
    always_comb begin
        zero_mode_is_reg = (op_cls == CL_STORE) || (op_cls >= CL_SHL && op_cls <= CL_SRA)
                        || (op_cls == CL_ROL) || (op_cls == CL_ROR) || (op_cls == CL_TEST)
                        || (op_cls == CL_PULL) || (op_cls == CL_NEG);
    end

    always_comb begin
        op_legal = 1'b1;
        op_two   = 1'b1;
        if (op_cls >= CL_RSV_LO && op_cls <= CL_RSV_HI) begin
            op_legal = 1'b0;
            op_two   = 1'b0;
        end else if (op_cls == CL_EXT_A) begin
            op_two = (op_mode <= MD_EXT_LAST_PW);
        end else if (op_cls == CL_EXT_B) begin
            op_two   = 1'b0;
            op_legal = (op_mode != MD_ZERO);
        end else if (op_cls == CL_BRANCH) begin
            op_two = (op_mode[1:0] != 2'b00);
        end else if (op_cls == CL_JUMP || op_cls == CL_OUT) begin
            op_two = 1'b1;
        end else if (op_cls == CL_IN) begin
            op_two = (op_mode != MD_ZERO);
        end else if (op_mode == MD_REG) begin
            op_two = 1'b0;
        end else if (op_mode == MD_ZERO) begin
            op_two = !zero_mode_is_reg;
        end
    end

endmodule

// File: rtl/ifd_fetch_fsm.sv
module ifd_fetch_fsm
    import ifd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              op_legal,
    input  logic              op_two,
    input  logic              out_ready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid,
    output logic              exc_pulse,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] pw_q,
    output logic              two_q,
    output logic [ADDR_W-1:0] pc_q
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

    ifd_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_OP;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_OP: if (rd_valid) begin
                if (!op_legal)   state_d = ST_TRAP;
                else if (op_two) state_d = ST_FETCH_PW;
                else             state_d = ST_PRESENT;
            end
            ST_FETCH_PW: if (rd_valid)  state_d = ST_PRESENT;
            ST_PRESENT:  if (out_ready) state_d = ST_FETCH_OP;
            ST_TRAP:                    state_d = ST_FETCH_OP;
        endcase
    end

    // Instruction, post-word and program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            ir_q  <= '0;
            pw_q  <= '0;
            two_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH_OP: if (rd_valid) begin
                    ir_q  <= rd_data;
                    pw_q  <= '0;
                    two_q <= op_legal && op_two;
                end
                ST_FETCH_PW: if (rd_valid) pw_q <= rd_data;
                ST_PRESENT:  if (out_ready) pc_q <= pc_q + (two_q ? STEP_TWO : STEP_ONE);
                ST_TRAP:     pc_q <= pc_q + STEP_ONE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req    = 1'b0;
        rd_addr   = pc_q;
        out_valid = 1'b0;
        exc_pulse = 1'b0;
        unique case (state_q)
            ST_FETCH_OP: rd_req = 1'b1;
            ST_FETCH_PW: begin
                rd_req  = 1'b1;
                rd_addr = pc_q + STEP_ONE;
            end
            ST_PRESENT:  out_valid = 1'b1;
            ST_TRAP:     exc_pulse = 1'b1;
        endcase
    end

endmodule

// File: rtl/ifd_fetch_decoder.sv
module ifd_fetch_decoder
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_req,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [4:0]        dec_class,
    output logic [2:0]        dec_mode,
    output logic [7:0]        dec_postbyte,
    output logic [3:0]        dec_reg_lo,
    output logic [3:0]        dec_reg_hi,
    output logic [15:0]       dec_postword,
    output logic              dec_two_word,
    output logic [ADDR_W-1:0] dec_pc,
    output logic              exc_opcode
);

    logic              legal_w, two_w;
    logic [WORD_W-1:0] ir_w;

    // Length and legality of the word arriving from memory
    ifd_opclass u_class (
        .op_cls   (mem_rdata[WORD_W-1 -: CLASS_W]),
        .op_mode  (mem_rdata[PB_W +: MODE_W]),
        .op_legal (legal_w),
        .op_two   (two_w)
    );

    ifd_fetch_fsm #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (mem_rvalid),
        .rd_data   (mem_rdata),
        .op_legal  (legal_w),
        .op_two    (two_w),
        .out_ready (dec_ready),
        .rd_req    (mem_req),
        .rd_addr   (mem_addr),
        .out_valid (dec_valid),
        .exc_pulse (exc_opcode),
        .ir_q      (ir_w),
        .pw_q      (dec_postword),
        .two_q     (dec_two_word),
        .pc_q      (dec_pc)
    );

    assign dec_class    = ir_w[WORD_W-1 -: CLASS_W];
    assign dec_mode     = ir_w[PB_W +: MODE_W];
    assign dec_postbyte = ir_w[PB_W-1:0];
    assign dec_reg_lo   = ir_w[NIB_W-1:0];
    assign dec_reg_hi   = ir_w[PB_W-1:NIB_W];

endmodule

// File: rtl/ifd_fetch_checker.sv
module ifd_fetch_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [7:0]        dec_postbyte,
    input logic [15:0]       dec_postword,
    input logic              dec_two_word,
    input logic [ADDR_W-1:0] dec_pc,
    input logic              exc_opcode
);

    // Input assumption: memory only answers a pending request (R9)
    assert_rvalid_on_req_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> mem_req);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_postbyte)
            && $stable(dec_postword) && $stable(dec_pc) && $stable(dec_two_word)));

    assert_no_req_while_valid_R8: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> !mem_req);

    assert_exc_single_R7: assert property (@(posedge clk) disable iff (rst)
        exc_opcode |=> !exc_opcode);

    assert_exc_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        exc_opcode |-> (!dec_valid && !mem_req));

    assert_single_word_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_two_word) |-> (dec_postword == 16'h0000));

    assert_pc_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |=> (mem_req &&
            mem_addr == $past(dec_pc + (dec_two_word ? ADDR_W'(2) : ADDR_W'(1)))));

endmodule

bind ifd_fetch_decoder ifd_fetch_checker #(.ADDR_W(ADDR_W)) u_ifd_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .dec_postbyte (dec_postbyte),
    .dec_postword (dec_postword),
    .dec_two_word (dec_two_word),
    .dec_pc       (dec_pc),
    .exc_opcode   (exc_opcode)
);

// File: tb/ifd_fetch_decoder_tb_top.sv
module ifd_fetch_decoder_tb_top;

    localparam int AW = 16;

    typedef struct {
        logic        is_exc;
        logic [4:0]  cls;
        logic [2:0]  mode;
        logic [7:0]  pb;
        logic [15:0] pw;
        logic        two;
        logic [15:0] pc;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_req;
    logic [15:0]   mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          dec_valid;
    logic          dec_ready = 1'b0;
    logic [4:0]    dec_class;
    logic [2:0]    dec_mode;
    logic [7:0]    dec_postbyte;
    logic [3:0]    dec_reg_lo, dec_reg_hi;
    logic [15:0]   dec_postword;
    logic          dec_two_word;
    logic [AW-1:0] dec_pc;
    logic          exc_opcode;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [0:63];
    int          wp = 0;
    item_t       exp_out[$];
    logic [15:0] exp_rd[$];

    always #10 clk = ~clk;

    ifd_fetch_decoder dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_req(mem_req),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .dec_class(dec_class), .dec_mode(dec_mode),
        .dec_postbyte(dec_postbyte), .dec_reg_lo(dec_reg_lo), .dec_reg_hi(dec_reg_hi),
        .dec_postword(dec_postword), .dec_two_word(dec_two_word), .dec_pc(dec_pc),
        .exc_opcode(exc_opcode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: place an instruction in memory and queue what must come out
    task automatic put(input string tag, input logic [4:0] c, input logic [2:0] m,
                       input logic [7:0] pb, input bit two, input logic [15:0] pw);
        item_t it;
        it.is_exc = 1'b0; it.cls = c; it.mode = m; it.pb = pb;
        it.two = two; it.pw = two ? pw : 16'h0; it.pc = 16'(wp); it.tag = tag;
        mem[wp] = {c, m, pb};
        exp_rd.push_back(16'(wp));
        if (two) begin
            mem[wp+1] = pw;
            exp_rd.push_back(16'(wp + 1));
        end
        exp_out.push_back(it);
        wp += two ? 2 : 1;
    endtask

    task automatic put_bad(input logic [4:0] c, input logic [2:0] m, input logic [7:0] pb);
        item_t it;
        it.is_exc = 1'b1; it.cls = c; it.mode = m; it.pb = pb;
        it.two = 1'b0; it.pw = 16'h0; it.pc = 16'(wp); it.tag = "R7";
        mem[wp] = {c, m, pb};
        mem[wp+1] = 16'h0000;
        exp_rd.push_back(16'(wp));
        exp_out.push_back(it);
        wp += 1;
    endtask

    // Memory model: answers a held request after 0..2 cycles
    initial begin
        int wait_n = 0;
        int rd_cnt = 0;
        bit pend = 0;
        logic [AW-1:0] first_addr = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_rvalid = 1'b0; pend = 0; wait_n = 0;
            end else if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                rd_cnt++;
                wait_n = rd_cnt % 3;
                pend = 0;
            end else if (mem_req) begin
                if (!pend) begin
                    pend = 1; first_addr = mem_addr;
                end
                if (wait_n == 0) begin
                    check(mem_addr == first_addr, "R9", "held address", mem_addr, first_addr);
                    if (exp_rd.size() > 0) begin
                        logic [15:0] ea;
                        ea = exp_rd.pop_front();
                        check(mem_addr == ea, "R3/R4/R6/R7", "read address", mem_addr, ea);
                    end
                    mem_rdata  = mem[mem_addr[5:0]];
                    mem_rvalid = 1'b1;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Consumer stall pattern
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk);
            #2;
            dec_ready = ((rc % 4) != 1);
            rc++;
        end
    end

    // Monitor: pops expected items and compares
    initial begin
        bit stalled = 0;
        bit exc_last = 0;
        logic [7:0]  s_pb;
        logic [15:0] s_pw;
        logic [AW-1:0] s_pc;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (stalled) begin
                    check(dec_valid == 1'b1, "R8", "valid held in stall", 32'(dec_valid), 1);
                    check(dec_postbyte == s_pb && dec_postword == s_pw && dec_pc == s_pc,
                          "R8", "bundle held in stall", dec_postword, s_pw);
                    check(mem_req == 1'b0, "R8", "no read in stall", 32'(mem_req), 0);
                end
                stalled = dec_valid && !dec_ready && exp_out.size() > 0;
                s_pb = dec_postbyte; s_pw = dec_postword; s_pc = dec_pc;
                if (exc_last)
                    check(exc_opcode == 1'b0, "R7", "exception one cycle", 32'(exc_opcode), 0);
                exc_last = exc_opcode;
                if (exc_opcode && exp_out.size() > 0) begin
                    item_t it;
                    it = exp_out.pop_front();
                    check(it.is_exc == 1'b1, "R7", "unexpected exception at item", 32'(it.pc), 32'hFFFF);
                    check(dec_valid == 1'b0, "R7", "no bundle on exception", 32'(dec_valid), 0);
                end
                if (dec_valid && dec_ready && exp_out.size() > 0) begin
                    item_t it;
                    it = exp_out.pop_front();
                    check(it.is_exc == 1'b0, "R7", "bundle for illegal opcode", 32'(dec_pc), 32'(it.pc));
                    check(dec_class == it.cls && dec_mode == it.mode && dec_postbyte == it.pb &&
                          dec_reg_lo == it.pb[3:0] && dec_reg_hi == it.pb[7:4],
                          "R2", "fields", {dec_class, dec_mode, dec_postbyte}, {it.cls, it.mode, it.pb});
                    check(dec_two_word == it.two && dec_postword == it.pw, it.tag, "post-word",
                          {dec_two_word, dec_postword}, {it.two, it.pw});
                    check(dec_pc == it.pc, "R10", "instruction address", dec_pc, it.pc);
                end
            end
        end
    end

    // Stimulus and sequencing
    initial begin
        int cyc = 0;
        for (int i = 0; i < 64; i++) mem[i] = 16'hF600;
        put("R4", 5'h00, 3'd0, 8'h21, 1, 16'h1234);
        put("R3", 5'h00, 3'd3, 8'h54, 0, 16'h0);
        put("R3", 5'h01, 3'd0, 8'h12, 0, 16'h0);
        put("R4", 5'h01, 3'd1, 8'h30, 1, 16'hBEEF);
        put("R3", 5'h02, 3'd3, 8'h67, 0, 16'h0);
        put("R3", 5'h06, 3'd0, 8'h42, 0, 16'h0);
        put("R4", 5'h06, 3'd4, 8'h31, 1, 16'h0040);
        put("R3", 5'h0F, 3'd3, 8'h25, 0, 16'h0);
        put("R3", 5'h11, 3'd0, 8'h90, 0, 16'h0);
        put_bad(5'h19, 3'd0, 8'hAA);
        put("R3", 5'h12, 3'd0, 8'h7F, 0, 16'h0);
        put("R5", 5'h12, 3'd3, 8'h05, 1, 16'h00C3);
        put("R5", 5'h13, 3'd0, 8'h11, 1, 16'h5A5A);
        put("R5", 5'h13, 3'd3, 8'h80, 1, 16'h0022);
        put("R3", 5'h15, 3'd0, 8'h00, 0, 16'h0);
        put("R5", 5'h16, 3'd0, 8'h05, 1, 16'h2000);
        put("R3", 5'h17, 3'd0, 8'h81, 0, 16'h0);
        put("R3", 5'h17, 3'd4, 8'h02, 0, 16'h0);
        put("R4", 5'h17, 3'd2, 8'h04, 1, 16'hFFF0);
        put_bad(5'h1D, 3'd7, 8'h33);
        put("R3", 5'h18, 3'd0, 8'h09, 0, 16'h0);
        put("R4", 5'h10, 3'd5, 8'h3C, 1, 16'h0100);
        put("R4", 5'h1E, 3'd1, 8'h70, 1, 16'h0003);
        put("R3", 5'h1E, 3'd6, 8'h00, 0, 16'h0);
        put_bad(5'h1F, 3'd0, 8'h00);
        put("R3", 5'h1F, 3'd3, 8'h00, 0, 16'h0);
        put("R4", 5'h0B, 3'd0, 8'h0E, 1, 16'h00FF);

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(mem_req == 1'b1, "R1", "reset mem_req", 32'(mem_req), 1);
        check(mem_addr == 16'h0, "R1", "reset mem_addr", mem_addr, 0);
        check(dec_valid == 1'b0, "R1", "reset dec_valid", 32'(dec_valid), 0);
        check(exc_opcode == 1'b0, "R1", "reset exc_opcode", 32'(exc_opcode), 0);

        while ((exp_out.size() > 0 || exp_rd.size() > 0) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 20000) begin
            fails++; checks++;
            $display("FAIL watchdog items_left=%0d expected=0", exp_out.size());
        end
        repeat (5) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule